// File: doc/BRIEF.md
# Linked-List Transmit DMA Engine

This block is a single-channel transmit DMA engine. It follows a chain of descriptors held in memory, reads the data buffer that each one points at, and sends that buffer one byte at a time on a valid/ready byte stream that feeds a device. A descriptor is three 32-bit words. Its per-buffer flags mark the end of the chain, the end of a packet and a request for an interrupt. When a buffer closes a packet, the engine writes the descriptor's count word back to memory with a "sent" bit set. Software can then see which packets have left.

Software supplies the address of the first descriptor and pulses start. While the channel runs, an active flag stays high. Software can also pulse an abort, or clear the sticky interrupt flag. A second status flag tells software whether the end-of-chain descriptor has already been fetched. Once it has, linking a further descriptor onto the chain has no effect. Memory is reached through one port for 32-bit words. That port carries both reads and the single write-back, and each access is one request held until one acknowledge.

Top module: `cdma_tx_engine`

## Requirements
- R1: A descriptor at byte address D occupies three words. D holds the buffer address, D+4 holds the count/flags word and D+8 holds the next-descriptor address. When the engine is idle, a start pulse takes D from `cfg_first_desc`. The low two bits of the buffer address are ignored, so buffers are word aligned.
- R2: Bits 13:0 of the count/flags word give the byte count N, with N from 0 to 16383. Exactly N bytes are sent from the buffer. A descriptor with N = 0 sends no bytes, but its flags are still acted on.
- R3: When `cfg_little` is 0, each data word is sent most significant byte first (bits 31:24 first). When `cfg_little` is 1, each data word is sent least significant byte first (bits 7:0 first). A final partial word sends only its first N mod 4 bytes in that order.
- R4: Bit 31 of the count/flags word marks the last descriptor. After that buffer the engine goes idle, and it never reads that descriptor's next-address word.
- R5: Bit 30 of the count/flags word marks the buffer's last byte as the end of a packet. `tx_last` is high with that byte and only with that byte. `tx_last` is never high without `tx_valid`.
- R6: Bit 29 of the count/flags word sets the sticky `sts_irq` flag once the buffer is finished. A `cfg_irq_clr` pulse drops it, unless a new interrupt is raised in the same cycle. `sts_irq` falls only after a clear or an abort.
- R7: After the last byte of a buffer whose bit 30 is set, the engine writes the count/flags word back to D+4 with bit 15 set. The write happens before the engine moves on. No write-back is made for a buffer without bit 30. Every write the engine makes has bit 15 set.
- R8: `sts_active` is high from the cycle after an accepted start until the end-of-chain buffer is finished. A start pulse while the engine is active is ignored. While the engine is idle it makes no memory request and sends no byte.
- R9: A `cfg_abort` pulse returns the engine to idle in the next cycle. It drops `tx_valid` and `mem_req` and clears `sts_irq` and `sts_eox_seen`. A later start runs normally.
- R10: `sts_eox_seen` goes high when a count/flags word with bit 31 set is read. It stays high until the next accepted start or an abort.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold steady.
- R12: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` steady, until `mem_ack` arrives. Read data is taken from `mem_rdata` in the cycle `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_start | input | 1 | Start pulse; ignored while active |
| cfg_first_desc | input | 32 | Byte address of the first descriptor |
| cfg_little | input | 1 | 1: send each data word least significant byte first |
| cfg_abort | input | 1 | Abort pulse: stop and clear the channel |
| cfg_irq_clr | input | 1 | Pulse to clear the interrupt flag |
| sts_active | output | 1 | Channel is walking a chain |
| sts_irq | output | 1 | Sticky interrupt flag |
| sts_eox_seen | output | 1 | End-of-chain descriptor already fetched |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1: write access (descriptor write-back) |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Device accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Byte ends a packet |

## Verification
The bench targets the following corner cases:

- **Zero-length buffers and partial last words.** A design that fetched one word too many, or sent padding bytes, would give a stream longer than the sum of the counts.
- **A buffer that ends a chain while its next pointer leads to a valid descriptor.** An engine that followed that pointer would send the second buffer and make an extra write-back.
- **Ending a packet in a zero-length buffer.** The packet must be written back, but no `tx_last` may be raised.
- **Both byte orders, with random back-pressure.** A swap of the byte order, or a byte that changes while it is stalled, shows up as a data mismatch.
- **Abort while a buffer is in flight, and a second start while busy.** An engine that restarted on the second start would send the other buffer. An abort that left a flag set would leave status behind for the next run.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

  // Bit positions inside the descriptor count/flags word.
  localparam int unsigned FLG_EOX  = 31;
  localparam int unsigned FLG_EOP  = 30;
  localparam int unsigned FLG_XIE  = 29;
  localparam int unsigned FLG_SENT = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_BUF,
    ST_GET_CNT,
    ST_GET_NXT,
    ST_DATA_RD,
    ST_DATA_TX,
    ST_WRBACK,
    ST_DESC_END
  } cdma_state_e;

endpackage

// File: rtl/cdma_unpack.sv
module cdma_unpack #(
  parameter int unsigned DW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          load,
  input  logic [DW-1:0]                 word,
  input  logic [$clog2(DW/8+1)-1:0]     nbytes,
  input  logic                          eop,
  input  logic                          little,
  output logic                          busy,
  output logic                          tx_valid,
  input  logic                          tx_ready,
  output logic [7:0]                    tx_data,
  output logic                          tx_last
);

  localparam int unsigned NBW = $clog2(DW/8 + 1);

  logic [DW-1:0]  word_q, word_d;
  logic [NBW-1:0] left_q, left_d;
  logic           eop_q, eop_d;
  logic           little_q, little_d;
  logic           advance;

  assign tx_valid = (left_q != '0);
  assign busy     = tx_valid;
  assign tx_data  = little_q ? word_q[7:0] : word_q[DW-1 -: 8];
  assign tx_last  = eop_q && (left_q == NBW'(1));
  assign advance  = tx_valid && tx_ready;

  always_comb begin
    word_d   = word_q;
    left_d   = left_q;
    eop_d    = eop_q;
    little_d = little_q;
    if (flush) begin
      left_d = '0;
      eop_d  = 1'b0;
    end else if (load) begin
      word_d   = word;
      left_d   = nbytes;
      eop_d    = eop;
      little_d = little;
    end else if (advance) begin
      word_d = little_q ? (word_q >> 8) : (word_q << 8);
      left_d = left_q - NBW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      left_q   <= '0;
      eop_q    <= 1'b0;
      little_q <= 1'b0;
    end else begin
      word_q   <= word_d;
      left_q   <= left_d;
      eop_q    <= eop_d;
      little_q <= little_d;
    end
  end

endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
  import cdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 14
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [AW-1:0]                 first_desc,
  input  logic                          abort,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [DW-1:0]                 mem_wdata,
  input  logic                          mem_ack,
  input  logic [DW-1:0]                 mem_rdata,
  output logic                          unp_load,
  output logic [$clog2(DW/8+1)-1:0]     unp_nbytes,
  output logic                          unp_eop,
  input  logic                          unp_busy,
  output logic                          desc_done,
  output logic                          desc_xie,
  output logic                          eox_fetched,
  output logic                          active
);

  localparam int unsigned BPW = DW / 8;
  localparam int unsigned NBW = $clog2(BPW + 1);
  localparam logic [AW-1:0] OFS_CNT    = AW'(BPW);
  localparam logic [AW-1:0] OFS_NXT    = AW'(2 * BPW);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BPW - 1);
  localparam logic [DW-1:0] SENT_MASK  = DW'(1) << FLG_SENT;

  cdma_state_e    state_q, state_d;
  logic [AW-1:0]  desc_q, desc_d;
  logic [AW-1:0]  nxt_q, nxt_d;
  logic [AW-1:0]  buf_q, buf_d;
  logic [DW-1:0]  cntw_q, cntw_d;
  logic [CW-1:0]  rem_q, rem_d;
  logic [NBW-1:0] chunk;

  // Where to go once the descriptor words are in, or a data word is drained.
  function automatic cdma_state_e body_state(input logic zero, input logic eop);
    if (!zero)     return ST_DATA_RD;
    else if (eop)  return ST_WRBACK;
    else           return ST_DESC_END;
  endfunction

  assign chunk      = (rem_q >= CW'(BPW)) ? NBW'(BPW) : rem_q[NBW-1:0];
  assign unp_nbytes = chunk;
  assign unp_eop    = cntw_q[FLG_EOP] && (rem_q <= CW'(BPW));
  assign desc_xie   = cntw_q[FLG_XIE];
  assign active     = (state_q != ST_IDLE);
  assign mem_wdata  = cntw_q | SENT_MASK;

  always_comb begin
    state_d     = state_q;
    desc_d      = desc_q;
    nxt_d       = nxt_q;
    buf_d       = buf_q;
    cntw_d      = cntw_q;
    rem_d       = rem_q;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = desc_q;
    unp_load    = 1'b0;
    desc_done   = 1'b0;
    eox_fetched = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          desc_d  = first_desc;
          state_d = ST_GET_BUF;
        end
      end
      ST_GET_BUF: begin
        mem_req  = 1'b1;
        mem_addr = desc_q;
        if (mem_ack) begin
          buf_d   = mem_rdata[AW-1:0] & ALIGN_MASK;
          state_d = ST_GET_CNT;
        end
      end
      ST_GET_CNT: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + OFS_CNT;
        if (mem_ack) begin
          cntw_d = mem_rdata;
          rem_d  = mem_rdata[CW-1:0];
          if (mem_rdata[FLG_EOX]) begin
            eox_fetched = 1'b1;
            state_d     = body_state(mem_rdata[CW-1:0] == '0, mem_rdata[FLG_EOP]);
          end else begin
            state_d = ST_GET_NXT;
          end
        end
      end
      ST_GET_NXT: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + OFS_NXT;
        if (mem_ack) begin
          nxt_d   = mem_rdata[AW-1:0];
          state_d = body_state(rem_q == '0, cntw_q[FLG_EOP]);
        end
      end
      ST_DATA_RD: begin
        mem_req  = 1'b1;
        mem_addr = buf_q;
        if (mem_ack) begin
          unp_load = 1'b1;
          rem_d    = rem_q - CW'(chunk);
          buf_d    = buf_q + OFS_CNT;
          state_d  = ST_DATA_TX;
        end
      end
      ST_DATA_TX: begin
        if (!unp_busy) begin
          state_d = body_state(rem_q == '0, cntw_q[FLG_EOP]);
        end
      end
      ST_WRBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = desc_q + OFS_CNT;
        if (mem_ack) begin
          state_d = ST_DESC_END;
        end
      end
      ST_DESC_END: begin
        desc_done = 1'b1;
        if (cntw_q[FLG_EOX]) begin
          state_d = ST_IDLE;
        end else begin
          desc_d  = nxt_q;
          state_d = ST_GET_BUF;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort) begin
      state_d     = ST_IDLE;
      unp_load    = 1'b0;
      desc_done   = 1'b0;
      eox_fetched = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      nxt_q   <= '0;
      buf_q   <= '0;
      cntw_q  <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      desc_q  <= desc_d;
      nxt_q   <= nxt_d;
      buf_q   <= buf_d;
      cntw_q  <= cntw_d;
      rem_q   <= rem_d;
    end
  end

endmodule

// File: rtl/cdma_status.sv
module cdma_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start_acc,
  input  logic abort,
  input  logic irq_clr,
  input  logic desc_done,
  input  logic desc_xie,
  input  logic eox_fetched,
  output logic irq,
  output logic eox_seen
);

  logic irq_d, irq_en;
  logic eox_d, eox_en;

  always_comb begin
    irq_en = abort || (desc_done && desc_xie) || irq_clr;
    if (abort)                       irq_d = 1'b0;
    else if (desc_done && desc_xie)  irq_d = 1'b1;
    else                             irq_d = 1'b0;

    eox_en = abort || start_acc || eox_fetched;
    eox_d  = !(abort || start_acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      eox_seen <= 1'b0;
    end else begin
      if (irq_en) irq      <= irq_d;
      if (eox_en) eox_seen <= eox_d;
    end
  end

endmodule

// File: rtl/cdma_tx_engine.sv
module cdma_tx_engine
  import cdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic [AW-1:0] cfg_first_desc,
  input  logic          cfg_little,
  input  logic          cfg_abort,
  input  logic          cfg_irq_clr,
  output logic          sts_active,
  output logic          sts_irq,
  output logic          sts_eox_seen,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last
);

  localparam int unsigned NBW = $clog2(DW/8 + 1);

  logic           rst_meta, rst_n_int;
  logic           unp_load, unp_eop, unp_busy;
  logic [NBW-1:0] unp_nbytes;
  logic           desc_done, desc_xie, eox_fetched;
  logic           start_acc;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  assign start_acc = cfg_start && !sts_active;

  cdma_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start       (cfg_start),
    .first_desc  (cfg_first_desc),
    .abort       (cfg_abort),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .unp_load    (unp_load),
    .unp_nbytes  (unp_nbytes),
    .unp_eop     (unp_eop),
    .unp_busy    (unp_busy),
    .desc_done   (desc_done),
    .desc_xie    (desc_xie),
    .eox_fetched (eox_fetched),
    .active      (sts_active)
  );

  cdma_unpack #(.DW(DW)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .flush    (cfg_abort),
    .load     (unp_load),
    .word     (mem_rdata),
    .nbytes   (unp_nbytes),
    .eop      (unp_eop),
    .little   (cfg_little),
    .busy     (unp_busy),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last)
  );

  cdma_status u_status (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_acc   (start_acc),
    .abort       (cfg_abort),
    .irq_clr     (cfg_irq_clr),
    .desc_done   (desc_done),
    .desc_xie    (desc_xie),
    .eox_fetched (eox_fetched),
    .irq         (sts_irq),
    .eox_seen    (sts_eox_seen)
  );

endmodule

// File: rtl/cdma_tx_engine_sva.sv
module cdma_tx_engine_sva
  import cdma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_abort,
  input logic          cfg_irq_clr,
  input logic          sts_active,
  input logic          sts_irq,
  input logic          sts_eox_seen,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last
);

  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cfg_abort) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !cfg_abort) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_abort |=> (!sts_active && !tx_valid && !mem_req && !sts_irq && !sts_eox_seen));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_active |-> (!mem_req && !tx_valid));

  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts_irq) |-> $past(cfg_irq_clr || cfg_abort));

  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  p_wb_sent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[FLG_SENT]);

  p_eox_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_eox_seen) |-> sts_active);

endmodule

bind cdma_tx_engine cdma_tx_engine_sva #(.AW(AW), .DW(DW)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_abort    (cfg_abort),
  .cfg_irq_clr  (cfg_irq_clr),
  .sts_active   (sts_active),
  .sts_irq      (sts_irq),
  .sts_eox_seen (sts_eox_seen),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .tx_last      (tx_last)
);

// File: tb/cdma_tx_engine_bench.sv
module cdma_tx_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0;
  logic [31:0] cfg_first_desc = '0;
  logic        cfg_little = 1'b0;
  logic        cfg_abort = 1'b0;
  logic        cfg_irq_clr = 1'b0;
  logic        sts_active, sts_irq, sts_eox_seen;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        tx_valid, tx_last;
  logic        tx_ready;
  logic [7:0]  tx_data;

  always #5 clk = ~clk;

  cdma_tx_engine u_cdma_tx_engine (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_first_desc(cfg_first_desc),
    .cfg_little(cfg_little), .cfg_abort(cfg_abort), .cfg_irq_clr(cfg_irq_clr),
    .sts_active(sts_active), .sts_irq(sts_irq), .sts_eox_seen(sts_eox_seen),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
  );

  int total = 0;
  int bad = 0;

  // Memory: contents written only by the stimulus process; design writes are logged.
  logic [31:0] mem [0:1023];
  logic [31:0] wb_addr [0:63];
  logic [31:0] wb_data [0:63];
  int          wb_n = 0;
  logic        stall_en = 1'b0;
  logic [7:0]  lfsr;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      tx_ready  <= 1'b0;
      lfsr      <= 8'h5a;
    end else begin
      lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready <= stall_en ? (lfsr[0] & lfsr[2]) | lfsr[5] : 1'b1;
      mem_ack  <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_we && wb_n < 64) begin
          wb_addr[wb_n] <= mem_addr;
          wb_data[wb_n] <= mem_wdata;
          wb_n          <= wb_n + 1;
        end
      end
    end
  end

  // Output capture and hold check, sampled at the falling edge.
  logic [7:0] cap_d [0:1023];
  logic       cap_l [0:1023];
  int         cap_n = 0;
  int         hold_err = 0;
  logic       pv = 1'b0, pr = 1'b0, pl = 1'b0, pa = 1'b0;
  logic [7:0] pd = '0;

  always @(negedge clk) begin
    if (pv && !pr && !pa && rst_n) begin
      if (!tx_valid || tx_data != pd || tx_last != pl) hold_err++;
    end
    if (tx_valid && tx_ready && cap_n < 1024) begin
      cap_d[cap_n] = tx_data;
      cap_l[cap_n] = tx_last;
      cap_n++;
    end
    pv = tx_valid; pr = tx_ready; pd = tx_data; pl = tx_last; pa = cfg_abort;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input int a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [7:0] exp_byte(input int base, input int i, input bit little);
    int j = i / 4;
    int k = i % 4;
    return little ? fb(base + 4*j + 3 - k) : fb(base + i);
  endfunction

  function automatic logic [31:0] cword(input int cnt, input logic [2:0] fl);
    return {fl, 15'd0, 14'(cnt)};
  endfunction

  // Fields: cnt_a[35:22] fl_a[21:19] cnt_b[18:5] fl_b[4:2] little[1] stall[0];
  // fl = {end-of-chain, end-of-packet, interrupt}.
  localparam int NV = 8;
  localparam logic [35:0] VEC [0:NV-1] = '{
    {14'd5,  3'b110, 14'd3, 3'b100, 1'b0, 1'b0},
    {14'd8,  3'b111, 14'd3, 3'b100, 1'b1, 1'b0},
    {14'd3,  3'b000, 14'd6, 3'b111, 1'b0, 1'b1},
    {14'd0,  3'b011, 14'd4, 3'b100, 1'b1, 1'b1},
    {14'd7,  3'b110, 14'd5, 3'b110, 1'b0, 1'b0},
    {14'd1,  3'b110, 14'd2, 3'b100, 1'b1, 1'b0},
    {14'd13, 3'b010, 14'd9, 3'b111, 1'b1, 1'b1},
    {14'd0,  3'b101, 14'd2, 3'b100, 1'b0, 1'b0}
  };

  int cap_base, wb_base;

  task automatic setup(input int ca, input logic [2:0] fa, input int cb,
                       input logic [2:0] fbl, input bit little, input bit stall);
    mem[0]  = 32'h100; mem[1]  = cword(ca, fa);  mem[2]  = 32'h010;
    mem[4]  = 32'h200; mem[5]  = cword(cb, fbl); mem[6]  = 32'h020;
    mem[8]  = 32'h300; mem[9]  = cword(5, 3'b100); mem[10] = 32'h0;
    @(negedge clk);
    cfg_little = little;
    stall_en   = stall;
    cap_base   = cap_n;
    wb_base    = wb_n;
  endtask

  task automatic launch(input logic [31:0] fd);
    cfg_first_desc = fd;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(sts_active == 1'b1, "R8", "active after start", sts_active, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      if (!sts_active) break;
      @(negedge clk);
    end
    chk(sts_active == 1'b0, "R8", "chain finished", sts_active, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_run(input int ca, input logic [2:0] fa, input int cb,
                           input logic [2:0] fbl, input bit little);
    logic [7:0] ed [0:63];
    logic       el [0:63];
    int         en = 0;
    int         got;
    bit         follow = !fa[2];
    bit         eirq = fa[0] || (follow && fbl[0]);
    int         ewb = 0;
    for (int i = 0; i < ca; i++) begin
      ed[en] = exp_byte(32'h100, i, little); el[en] = fa[1] && (i == ca - 1); en++;
    end
    if (follow) begin
      for (int i = 0; i < cb; i++) begin
        ed[en] = exp_byte(32'h200, i, little); el[en] = fbl[1] && (i == cb - 1); en++;
      end
    end
    got = cap_n - cap_base;
    chk(got == en, "R2", "byte count (R4 stop at end of chain)", got, en);
    for (int i = 0; i < en && i < got; i++) begin
      chk(cap_d[cap_base+i] == ed[i], "R3", "data byte via R1 buffer pointer",
          cap_d[cap_base+i], ed[i]);
      chk(cap_l[cap_base+i] == el[i], "R5", "last marker", cap_l[cap_base+i], el[i]);
    end
    // Expected write-backs in order.
    if (fa[1]) begin
      chk(wb_n > wb_base + ewb && wb_addr[wb_base+ewb] == 32'h4, "R7", "writeback A address",
          wb_addr[wb_base+ewb], 32'h4);
      chk(wb_data[wb_base+ewb] == (cword(ca, fa) | 32'h8000), "R7", "writeback A data",
          wb_data[wb_base+ewb], cword(ca, fa) | 32'h8000);
      ewb++;
    end
    if (follow && fbl[1]) begin
      chk(wb_n > wb_base + ewb && wb_addr[wb_base+ewb] == 32'h14, "R7", "writeback B address",
          wb_addr[wb_base+ewb], 32'h14);
      chk(wb_data[wb_base+ewb] == (cword(cb, fbl) | 32'h8000), "R7", "writeback B data",
          wb_data[wb_base+ewb], cword(cb, fbl) | 32'h8000);
      ewb++;
    end
    chk(wb_n - wb_base == ewb, "R4", "number of writebacks", wb_n - wb_base, ewb);
    chk(sts_irq == eirq, "R6", "interrupt flag", sts_irq, eirq);
    chk(sts_eox_seen == 1'b1, "R10", "end-of-chain seen", sts_eox_seen, 1);
    chk(hold_err == 0, "R11", "stalled byte held", hold_err, 0);
    if (eirq) begin
      cfg_irq_clr = 1'b1;
      @(negedge clk);
      cfg_irq_clr = 1'b0;
      chk(sts_irq == 1'b0, "R6", "interrupt cleared", sts_irq, 0);
    end
  endtask

  task automatic run_chain(input int ca, input logic [2:0] fa, input int cb,
                           input logic [2:0] fbl, input bit little, input bit stall);
    setup(ca, fa, cb, fbl, little, stall);
    launch(32'h0);
    wait_idle();
    check_run(ca, fa, cb, fbl, little);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R8 watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int w = 0; w < 1024; w++) begin
      mem[w] = {fb(4*w), fb(4*w+1), fb(4*w+2), fb(4*w+3)};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state.
    chk(sts_active == 1'b0, "R8", "reset active", sts_active, 0);
    chk(sts_irq == 1'b0, "R6", "reset irq", sts_irq, 0);
    chk(sts_eox_seen == 1'b0, "R10", "reset eox seen", sts_eox_seen, 0);
    chk(tx_valid == 1'b0 && mem_req == 1'b0, "R12", "reset quiet ports", {tx_valid, mem_req}, 0);

    // Vector table.
    for (int v = 0; v < NV; v++) begin
      run_chain(int'(VEC[v][35:22]), VEC[v][21:19], int'(VEC[v][18:5]), VEC[v][4:2],
                VEC[v][1], VEC[v][0]);
    end

    // R8: a second start while active is ignored.
    setup(13, 3'b110, 3, 3'b100, 1'b0, 1'b1);
    launch(32'h0);
    repeat (3) @(negedge clk);
    cfg_first_desc = 32'h10;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(sts_active == 1'b1, "R8", "still active after second start", sts_active, 1);
    wait_idle();
    check_run(13, 3'b110, 3, 3'b100, 1'b0);

    // R9: abort in the middle of a long buffer, after an interrupt was raised.
    setup(0, 3'b001, 40, 3'b111, 1'b0, 1'b1);
    launch(32'h0);
    for (int i = 0; i < 200; i++) begin
      if (sts_irq) break;
      @(negedge clk);
    end
    chk(sts_irq == 1'b1, "R6", "irq after zero-length buffer", sts_irq, 1);
    repeat (12) @(negedge clk);
    chk(sts_eox_seen == 1'b1, "R10", "eox seen mid-run", sts_eox_seen, 1);
    cfg_abort = 1'b1;
    @(negedge clk);
    cfg_abort = 1'b0;
    chk(sts_active == 1'b0, "R9", "abort idles", sts_active, 0);
    chk(tx_valid == 1'b0 && mem_req == 1'b0, "R9", "abort quiets ports", {tx_valid, mem_req}, 0);
    chk(sts_irq == 1'b0, "R9", "abort clears irq", sts_irq, 0);
    chk(sts_eox_seen == 1'b0, "R9", "abort clears eox seen", sts_eox_seen, 0);
    chk(cap_n - cap_base < 40, "R9", "buffer cut short", cap_n - cap_base, 39);
    chk(wb_n == wb_base, "R9", "no writeback after abort", wb_n - wb_base, 0);
    repeat (5) @(negedge clk);
    chk(sts_active == 1'b0, "R9", "stays idle", sts_active, 0);

    // Recovery after abort.
    run_chain(6, 3'b110, 3, 3'b100, 1'b1, 1'b0);

    finish_run();
  end

endmodule